// File: doc/BRIEF.md
# Receive Descriptor Ring Filler

This block accepts one received frame at a time on a byte stream and stores it in a local frame store. It then walks a ring of 8-byte receive descriptors in system memory and spreads the frame across the buffers those descriptors point to. A buffer never takes more than a programmable number of bytes. When parse depth is enabled, a zeroed control block is written at the head of the first buffer. Four zero bytes that stand in for the CRC follow the frame data and count toward its size. Each descriptor is written back with its byte count and status flags. An event is posted per buffer, and an interrupt is pulsed when that event is unmasked.

The input stream uses valid/ready. A byte is taken on a clock edge where `in_valid` and `in_ready` are both high, and `in_last` marks the final byte. `in_ready` is high only while the block is idle or collecting a frame. It stays low for the whole descriptor walk and while the ring is halted, so the sender holds its next frame. If the walk runs out of empty descriptors, the block halts. It keeps the unplaced part of the frame and carries on from the current descriptor when `halt_resume` is pulsed.

Memory is one 32-bit word port. Byte address A lives in word A with its low two bits cleared, in lane 3-(A mod 4), so the byte at offset 0 occupies bits 31:24. A request holds `mem_req`, `mem_addr`, `mem_we`, `mem_be` and `mem_wdata` unchanged until `mem_ready` is high on a clock edge. Read data returns with `mem_rvalid` on a later cycle, and only one read is outstanding at a time.

A descriptor holds, in byte order:
- offset 0–1: flags;
- offset 2–3: length;
- offset 4–7: buffer address.

With `desc_le` low each field is most significant byte first. With `desc_le` high each field is least significant byte first.

The flag bits that matter are:
- 15: empty;
- 13: wrap;
- 11: last;
- 10: first;
- 5: too long;
- 3: too short.

`max_buf_len` must be at least 1 and larger than the control block.

Top module: `rx_ring_filler`

## Requirements
- R1: After reset `in_ready` is 1, `halted` is 0 and no memory request is made; `in_ready` is 0 from the cycle after the last byte of an accepted frame until its descriptor walk ends, and while halted.
- R2: A frame whose last byte arrives while `rx_en` is 0 or `grace_stop` is 1 is consumed and discarded: no memory request is made and `cur_ptr` is unchanged.
- R3: With `short_reject` set, a frame of fewer than 60 bytes is discarded like R2; a 60-byte frame is accepted.
- R4: With `parse_depth` nonzero, 8 + `align_pad` zero bytes are written at the start of the first buffer, before the frame data, and are counted in its length field.
- R5: Four zero bytes follow the frame data in the buffer stream; the frame size used for status is the received byte count plus 4.
- R6: Each buffer receives at most `max_buf_len` bytes, written one byte per request; the written-back length field is the number of bytes placed in that buffer, and the empty bit (15) is cleared.
- R7: Only the first descriptor used for a frame has the first bit (10) set in its write-back, including after a halt and resume.
- R8: On the final descriptor, bits 9:0 are cleared, the last bit (11) is set, bit 5 is set when the size is at least `max_frame`, and bit 3 is set when the size is below 64; the wrap (13) and interrupt (12) bits are kept.
- R9: Each write-back pulses `ev_buf` (non-final) or `ev_frame` (final) for one cycle, never both; `irq` pulses with `ev_frame` when `mask_frame` is 1 and with `ev_buf` when `mask_buf` is 1.
- R10: After each write-back `cur_ptr` moves to `ring_base` when the descriptor's wrap bit (13) is set, else to `cur_ptr` + 8; `cur_ptr` stays 8-byte aligned, and `ptr_load` sets it while idle.
- R11: When a descriptor without the empty bit is read, the walk stops with `cur_ptr` on that descriptor; when `cur_ptr` returns to the descriptor where the walk (or resume) began, the walk stops. In either case with data left, `halted` is 1, and a `halt_resume` pulse continues the frame from `cur_ptr`.
- R12: With `desc_le` high, the flags, length and buffer address fields are read and written least significant byte first.
- R13: A memory request keeps its address, write enable, byte enables and write data unchanged until accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Frame byte valid |
| in_ready | output | 1 | Block can take a byte |
| in_data | input | 8 | Frame byte |
| in_last | input | 1 | Final byte of the frame |
| rx_en | input | 1 | Receive enable |
| grace_stop | input | 1 | Graceful stop request; discard incoming frames |
| short_reject | input | 1 | Discard frames under 60 bytes |
| parse_depth | input | 2 | Nonzero prepends the control block |
| align_pad | input | 5 | Extra control block bytes |
| desc_le | input | 1 | Descriptor fields least significant byte first |
| max_buf_len | input | 16 | Bytes per buffer limit |
| max_frame | input | 16 | Size at or above which the too-long bit is set |
| ring_base | input | 32 | Address of the first descriptor |
| ptr_load | input | 1 | Load `ptr_value` into the current pointer while idle |
| ptr_value | input | 32 | Pointer value to load |
| halt_resume | input | 1 | Pulse to restart a halted ring |
| mask_frame | input | 1 | Enable interrupt on frame event |
| mask_buf | input | 1 | Enable interrupt on buffer event |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 32 | Word-aligned address |
| mem_be | output | 4 | Byte lane enables (bit 3 = offset 0) |
| mem_wdata | output | 32 | Write data |
| mem_ready | input | 1 | Request accepted this cycle |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Read data |
| cur_ptr | output | 32 | Current descriptor pointer |
| halted | output | 1 | Ring halted with data pending |
| ev_frame | output | 1 | Frame-complete event pulse |
| ev_buf | output | 1 | Buffer-complete event pulse |
| irq | output | 1 | Receive interrupt pulse |

## Verification
Frames are sent in several shapes:
- a short frame that fits one buffer;
- a long frame split over three buffers behind a control block, with a wrapping last descriptor;
- a frame that hits the size limit;
- the same kind of short frame with byte-reversed descriptors.

Together these separate the first/last/too-short/too-long flag combinations and show where the pointer ends up. Discard patterns cover the gating inputs and the 59/60-byte short boundary, and check that memory stays untouched. Two halt patterns tell the non-empty-descriptor stop apart from the full-lap stop, and both are resumed. Write-backs are compared in order against expected descriptor images, and buffer contents are compared byte by byte.

// File: rtl/rxr_pkg.sv
package rxr_pkg;

  typedef enum logic [2:0] {
    ST_CAP, ST_RD0, ST_RD0W, ST_RD1, ST_RD1W, ST_DATA, ST_WB, ST_HALT
  } walk_st_t;

  localparam int FLG_EMPTY = 15;
  localparam int FLG_WRAP  = 13;
  localparam int FLG_LAST  = 11;
  localparam int FLG_FIRST = 10;
  localparam int FLG_LONG  = 5;
  localparam int FLG_SHORT = 3;

  localparam int REJECT_BELOW = 60;
  localparam int SHORT_BELOW  = 64;
  localparam int CTRL_BASE    = 8;
  localparam int CRC_BYTES    = 4;
  localparam int DESC_BYTES   = 8;

  typedef struct packed {
    logic [15:0] flags;
    logic [15:0] len;
  } desc_hdr_t;

  function automatic logic [15:0] swap16(input logic [15:0] v);
    return {v[7:0], v[15:8]};
  endfunction

  function automatic logic [31:0] swap32(input logic [31:0] v);
    return {v[7:0], v[15:8], v[23:16], v[31:24]};
  endfunction

endpackage

// File: rtl/rxr_frame_store.sv
module rxr_frame_store #(
  parameter int DEPTH = 2048,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [7:0]    wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [7:0]    rd_data
);

  logic [7:0] store_q [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) store_q[wr_addr] <= wr_data;
  end

  assign rd_data = store_q[rd_addr];

endmodule

// File: rtl/rxr_desc_codec.sv
module rxr_desc_codec
  import rxr_pkg::*;
(
  input  logic        le,
  input  logic [31:0] rd_word,
  output desc_hdr_t   rd_hdr,
  output logic [31:0] rd_bufptr,
  input  desc_hdr_t   wb_hdr,
  output logic [31:0] wb_word
);

  always_comb begin
    if (le) begin
      rd_hdr.flags = swap16(rd_word[31:16]);
      rd_hdr.len   = swap16(rd_word[15:0]);
      rd_bufptr    = swap32(rd_word);
      wb_word      = {swap16(wb_hdr.flags), swap16(wb_hdr.len)};
    end else begin
      rd_hdr.flags = rd_word[31:16];
      rd_hdr.len   = rd_word[15:0];
      rd_bufptr    = rd_word;
      wb_word      = {wb_hdr.flags, wb_hdr.len};
    end
  end

endmodule

// File: rtl/rxr_event_gen.sv
module rxr_event_gen (
  input  logic clk,
  input  logic rst_n,
  input  logic fire,
  input  logic is_last,
  input  logic mask_frame,
  input  logic mask_buf,
  output logic ev_frame,
  output logic ev_buf,
  output logic irq
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ev_frame <= 1'b0;
      ev_buf   <= 1'b0;
      irq      <= 1'b0;
    end else begin
      ev_frame <= fire && is_last;
      ev_buf   <= fire && !is_last;
      irq      <= fire && ((is_last && mask_frame) || (!is_last && mask_buf));
    end
  end

  p_event_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(ev_frame && ev_buf));

  p_irq_source_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (ev_frame || ev_buf));

endmodule

// File: rtl/rxr_walker.sv
module rxr_walker
  import rxr_pkg::*;
#(
  parameter int DEPTH = 2048,
  parameter int LW    = 16,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [7:0]    in_data,
  input  logic          in_last,
  input  logic          rx_en,
  input  logic          grace_stop,
  input  logic          short_reject,
  input  logic [1:0]    parse_depth,
  input  logic [4:0]    align_pad,
  input  logic          desc_le,
  input  logic [LW-1:0] max_buf_len,
  input  logic [LW-1:0] max_frame,
  input  logic [31:0]   ring_base,
  input  logic          ptr_load,
  input  logic [31:0]   ptr_value,
  input  logic          halt_resume,
  output logic          st_wr_en,
  output logic [AW-1:0] st_wr_addr,
  output logic [7:0]    st_wr_data,
  output logic [AW-1:0] st_rd_addr,
  input  logic [7:0]    st_rd_data,
  output logic          mem_req,
  output logic          mem_we,
  output logic [31:0]   mem_addr,
  output logic [3:0]    mem_be,
  output logic [31:0]   mem_wdata,
  input  logic          mem_ready,
  input  logic          mem_rvalid,
  input  logic [31:0]   mem_rdata,
  output logic [31:0]   cur_ptr,
  output logic          halted,
  output logic          ev_fire,
  output logic          ev_last
);

  walk_st_t      state_q;
  logic [LW-1:0] cap_cnt_q, len_q, fcb_q, total_q, pos_q, cnt_q;
  logic          first_q;
  logic [31:0]   cur_ptr_q, start_ptr_q, bufptr_q;
  logic [15:0]   flags_q;

  desc_hdr_t     rd_hdr, wb_hdr;
  logic [31:0]   rd_bufptr, wb_word;

  logic [31:0]   base_al, ptr_next, byte_addr;
  logic [LW-1:0] cap_next, frame_size, fcb_new;
  logic          keep_frame, last_buf, in_data_zone;
  logic [7:0]    out_byte;

  rxr_desc_codec u_codec (
    .le        (desc_le),
    .rd_word   (mem_rdata),
    .rd_hdr    (rd_hdr),
    .rd_bufptr (rd_bufptr),
    .wb_hdr    (wb_hdr),
    .wb_word   (wb_word)
  );

  // capture path
  assign in_ready   = (state_q == ST_CAP);
  assign st_wr_en   = in_ready && in_valid && (cap_cnt_q < LW'(DEPTH));
  assign st_wr_addr = cap_cnt_q[AW-1:0];
  assign st_wr_data = in_data;
  assign cap_next   = cap_cnt_q + LW'(st_wr_en);
  assign keep_frame = rx_en && !grace_stop &&
                      !(short_reject && (cap_next < LW'(REJECT_BELOW)));
  assign fcb_new    = (parse_depth != 2'd0) ? LW'(CTRL_BASE) + LW'(align_pad) : '0;

  // placement stream: control block, frame data, CRC stand-in
  assign in_data_zone = (pos_q >= fcb_q) && (pos_q < fcb_q + len_q);
  assign st_rd_addr   = AW'(pos_q - fcb_q);
  assign out_byte     = in_data_zone ? st_rd_data : 8'h00;
  assign byte_addr    = bufptr_q + {{(32-LW){1'b0}}, cnt_q};

  assign frame_size = len_q + LW'(CRC_BYTES);
  assign last_buf   = (pos_q == total_q);
  assign base_al    = ring_base & ~32'h7;
  assign ptr_next   = flags_q[FLG_WRAP] ? base_al : cur_ptr_q + 32'(DESC_BYTES);

  always_comb begin
    wb_hdr.flags             = flags_q;
    wb_hdr.flags[FLG_EMPTY]  = 1'b0;
    wb_hdr.flags[FLG_FIRST]  = first_q;
    if (last_buf) begin
      wb_hdr.flags[9:0]      = '0;
      wb_hdr.flags[FLG_LAST] = 1'b1;
      wb_hdr.flags[FLG_LONG] = (frame_size >= max_frame);
      wb_hdr.flags[FLG_SHORT]= (frame_size < LW'(SHORT_BELOW));
    end
    wb_hdr.len = 16'(cnt_q);
  end

  // memory request generation
  always_comb begin
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = '0;
    mem_be    = 4'h0;
    mem_wdata = '0;
    unique case (state_q)
      ST_RD0: begin
        mem_req  = 1'b1;
        mem_addr = cur_ptr_q;
        mem_be   = 4'hf;
      end
      ST_RD1: begin
        mem_req  = 1'b1;
        mem_addr = cur_ptr_q + 32'd4;
        mem_be   = 4'hf;
      end
      ST_DATA: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = {byte_addr[31:2], 2'b00};
        mem_be    = 4'b1000 >> byte_addr[1:0];
        mem_wdata = {4{out_byte}};
      end
      ST_WB: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = cur_ptr_q;
        mem_be    = 4'hf;
        mem_wdata = wb_word;
      end
      default: ;
    endcase
  end

  assign ev_fire = (state_q == ST_WB) && mem_ready;
  assign ev_last = last_buf;
  assign cur_ptr = cur_ptr_q;
  assign halted  = (state_q == ST_HALT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q     <= ST_CAP;
      cap_cnt_q   <= '0;
      len_q       <= '0;
      fcb_q       <= '0;
      total_q     <= '0;
      pos_q       <= '0;
      cnt_q       <= '0;
      first_q     <= 1'b0;
      cur_ptr_q   <= '0;
      start_ptr_q <= '0;
      bufptr_q    <= '0;
      flags_q     <= '0;
    end else begin
      unique case (state_q)
        ST_CAP: begin
          if (ptr_load && cap_cnt_q == '0 && !in_valid) begin
            cur_ptr_q <= ptr_value & ~32'h7;
          end
          if (in_valid) begin
            cap_cnt_q <= cap_next;
            if (in_last) begin
              cap_cnt_q <= '0;
              if (keep_frame) begin
                len_q       <= cap_next;
                fcb_q       <= fcb_new;
                total_q     <= fcb_new + cap_next + LW'(CRC_BYTES);
                pos_q       <= '0;
                first_q     <= 1'b1;
                start_ptr_q <= cur_ptr_q;
                state_q     <= ST_RD0;
              end
            end
          end
        end
        ST_RD0: if (mem_ready) state_q <= ST_RD0W;
        ST_RD0W: begin
          if (mem_rvalid) begin
            flags_q <= rd_hdr.flags;
            state_q <= rd_hdr.flags[FLG_EMPTY] ? ST_RD1 : ST_HALT;
          end
        end
        ST_RD1: if (mem_ready) state_q <= ST_RD1W;
        ST_RD1W: begin
          if (mem_rvalid) begin
            bufptr_q <= rd_bufptr;
            cnt_q    <= '0;
            state_q  <= ST_DATA;
          end
        end
        ST_DATA: begin
          if (mem_ready) begin
            pos_q <= pos_q + 1'b1;
            cnt_q <= cnt_q + 1'b1;
            if ((pos_q + 1'b1 == total_q) || (cnt_q + 1'b1 == max_buf_len)) begin
              state_q <= ST_WB;
            end
          end
        end
        ST_WB: begin
          if (mem_ready) begin
            first_q   <= 1'b0;
            cur_ptr_q <= ptr_next;
            if (last_buf)                     state_q <= ST_CAP;
            else if (ptr_next == start_ptr_q) state_q <= ST_HALT;
            else                              state_q <= ST_RD0;
          end
        end
        ST_HALT: begin
          if (halt_resume) begin
            start_ptr_q <= cur_ptr_q;
            state_q     <= ST_RD0;
          end
        end
        default: state_q <= ST_CAP;
      endcase
    end
  end

  p_req_hold_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)
                                 && $stable(mem_be) && $stable(mem_wdata)));

  p_buf_limit_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_DATA) |-> (cnt_q < max_buf_len));

  p_one_lane_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we && mem_be != 4'hf) |-> $onehot(mem_be));

  p_ptr_align_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cur_ptr_q[2:0] == 3'b000);

  p_halt_blocks_r11: assert property (@(posedge clk) disable iff (!rst_n)
    halted |-> !in_ready);

  p_pos_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    pos_q <= total_q);

endmodule

// File: rtl/rx_ring_filler.sv
module rx_ring_filler #(
  parameter int DEPTH = 2048,
  parameter int LW    = 16,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [7:0]    in_data,
  input  logic          in_last,
  input  logic          rx_en,
  input  logic          grace_stop,
  input  logic          short_reject,
  input  logic [1:0]    parse_depth,
  input  logic [4:0]    align_pad,
  input  logic          desc_le,
  input  logic [LW-1:0] max_buf_len,
  input  logic [LW-1:0] max_frame,
  input  logic [31:0]   ring_base,
  input  logic          ptr_load,
  input  logic [31:0]   ptr_value,
  input  logic          halt_resume,
  input  logic          mask_frame,
  input  logic          mask_buf,
  output logic          mem_req,
  output logic          mem_we,
  output logic [31:0]   mem_addr,
  output logic [3:0]    mem_be,
  output logic [31:0]   mem_wdata,
  input  logic          mem_ready,
  input  logic          mem_rvalid,
  input  logic [31:0]   mem_rdata,
  output logic [31:0]   cur_ptr,
  output logic          halted,
  output logic          ev_frame,
  output logic          ev_buf,
  output logic          irq
);

  logic          st_wr_en;
  logic [AW-1:0] st_wr_addr, st_rd_addr;
  logic [7:0]    st_wr_data, st_rd_data;
  logic          ev_fire, ev_last;

  rxr_frame_store #(.DEPTH(DEPTH)) u_store (
    .clk     (clk),
    .wr_en   (st_wr_en),
    .wr_addr (st_wr_addr),
    .wr_data (st_wr_data),
    .rd_addr (st_rd_addr),
    .rd_data (st_rd_data)
  );

  rxr_walker #(.DEPTH(DEPTH), .LW(LW)) u_walk (
    .clk          (clk),
    .rst_n        (rst_n),
    .in_valid     (in_valid),
    .in_ready     (in_ready),
    .in_data      (in_data),
    .in_last      (in_last),
    .rx_en        (rx_en),
    .grace_stop   (grace_stop),
    .short_reject (short_reject),
    .parse_depth  (parse_depth),
    .align_pad    (align_pad),
    .desc_le      (desc_le),
    .max_buf_len  (max_buf_len),
    .max_frame    (max_frame),
    .ring_base    (ring_base),
    .ptr_load     (ptr_load),
    .ptr_value    (ptr_value),
    .halt_resume  (halt_resume),
    .st_wr_en     (st_wr_en),
    .st_wr_addr   (st_wr_addr),
    .st_wr_data   (st_wr_data),
    .st_rd_addr   (st_rd_addr),
    .st_rd_data   (st_rd_data),
    .mem_req      (mem_req),
    .mem_we       (mem_we),
    .mem_addr     (mem_addr),
    .mem_be       (mem_be),
    .mem_wdata    (mem_wdata),
    .mem_ready    (mem_ready),
    .mem_rvalid   (mem_rvalid),
    .mem_rdata    (mem_rdata),
    .cur_ptr      (cur_ptr),
    .halted       (halted),
    .ev_fire      (ev_fire),
    .ev_last      (ev_last)
  );

  rxr_event_gen u_evt (
    .clk        (clk),
    .rst_n      (rst_n),
    .fire       (ev_fire),
    .is_last    (ev_last),
    .mask_frame (mask_frame),
    .mask_buf   (mask_buf),
    .ev_frame   (ev_frame),
    .ev_buf     (ev_buf),
    .irq        (irq)
  );

endmodule

// File: tb/rx_ring_filler_tb.sv
module rx_ring_filler_tb;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 0, in_last = 0, in_ready;
  logic [7:0] in_data = 0;
  logic rx_en = 1, grace_stop = 0, short_reject = 0, desc_le = 0;
  logic [1:0] parse_depth = 0;
  logic [4:0] align_pad = 0;
  logic [15:0] max_buf_len = 16'd64, max_frame = 16'd1518;
  logic [31:0] ring_base = 32'h100, ptr_value = 32'h100;
  logic ptr_load = 0, halt_resume = 0, mask_frame = 1, mask_buf = 0;
  logic mem_req, mem_we, mem_ready = 0, mem_rvalid = 0;
  logic [31:0] mem_addr, mem_wdata, mem_rdata = 0, cur_ptr;
  logic [3:0] mem_be;
  logic halted, ev_frame, ev_buf, irq;

  rx_ring_filler u_dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  logic [7:0] mem [0:4095];
  int cyc = 0;
  int total = 0, bad = 0;
  int n_frame = 0, n_buf = 0, n_irq = 0, n_req = 0;
  logic [63:0] exp_q [$];

  // memory model
  always @(posedge clk) begin
    cyc <= cyc + 1;
    mem_ready <= (cyc % 3) != 0;
    mem_rvalid <= 1'b0;
    if (mem_req && mem_ready) begin
      if (mem_we) begin
        for (int k = 0; k < 4; k++)
          if (mem_be[3-k]) mem[(mem_addr[11:0] + k) & 12'hfff] = mem_wdata[31-8*k -: 8];
      end else begin
        mem_rvalid <= 1'b1;
        mem_rdata <= {mem[mem_addr[11:0]], mem[mem_addr[11:0]+1],
                      mem[mem_addr[11:0]+2], mem[mem_addr[11:0]+3]};
      end
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n) begin
      if (ev_frame) n_frame++;
      if (ev_buf) n_buf++;
      if (irq) n_irq++;
      if (mem_req) n_req++;
      if (mem_req && mem_ready && mem_we && mem_be == 4'hf) begin
        logic [15:0] f, l;
        logic [63:0] e;
        f = desc_le ? {mem_wdata[23:16], mem_wdata[31:24]} : mem_wdata[31:16];
        l = desc_le ? {mem_wdata[7:0], mem_wdata[15:8]} : mem_wdata[15:0];
        if (exp_q.size() == 0) begin
          chk(0, "R6", "unexpected write-back", {mem_addr, f, l}, 0);
        end else begin
          e = exp_q.pop_front();
          chk({mem_addr, f, l} == e, "R8", "descriptor write-back {addr,flags,len}",
              {mem_addr, f, l}, e);
        end
      end
    end
  end

  task automatic set_desc(input int i, input logic [15:0] fl);
    int a;
    logic [31:0] bp;
    a = 32'h100 + 8 * i;
    bp = 32'h400 + 32'h100 * i;
    if (desc_le) begin
      mem[a] = fl[7:0]; mem[a+1] = fl[15:8]; mem[a+2] = 0; mem[a+3] = 0;
      mem[a+4] = bp[7:0]; mem[a+5] = bp[15:8]; mem[a+6] = bp[23:16]; mem[a+7] = bp[31:24];
    end else begin
      mem[a] = fl[15:8]; mem[a+1] = fl[7:0]; mem[a+2] = 0; mem[a+3] = 0;
      mem[a+4] = bp[31:24]; mem[a+5] = bp[23:16]; mem[a+6] = bp[15:8]; mem[a+7] = bp[7:0];
    end
  endtask

  task automatic refill();
    for (int i = 0; i < 3; i++) set_desc(i, 16'h9000);
    set_desc(3, 16'hB000);
  endtask

  task automatic expect_wb(input logic [31:0] a, input logic [15:0] f, input logic [15:0] l);
    exp_q.push_back({a, f, l});
  endtask

  task automatic send_frame(input int n, input int seed);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1; in_data = 8'(seed + i); in_last = (i == n - 1);
      while (!in_ready) @(negedge clk);
    end
    @(negedge clk);
    in_valid = 0; in_last = 0;
  endtask

  task automatic wait_idle();
    repeat (2) @(negedge clk);
    while (!in_ready && !halted) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  // compare buffer bytes: stream = fcb zeros, data, 4 zeros
  task automatic check_data(input int n, input int seed, input int fcb, input int mb,
                            input int bufs[$], input string req);
    int p = 0, tot, bi = 0, miss = 0;
    tot = fcb + n + 4;
    while (p < tot) begin
      for (int c = 0; c < mb && p < tot; c++) begin
        logic [7:0] e;
        e = (p >= fcb && p < fcb + n) ? 8'(seed + p - fcb) : 8'h00;
        if (mem[bufs[bi] + c] !== e) miss++;
        p++;
      end
      bi++;
    end
    chk(miss == 0, req, "buffer bytes mismatching", miss, 0);
  endtask

  initial begin
    int f0, b0, i0, r0;
    for (int i = 0; i < 4096; i++) mem[i] = 8'h5a;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(in_ready == 1 && halted == 0 && mem_req == 0 && irq == 0, "R1",
        "reset state", {in_ready, halted, mem_req, irq}, 4'b1000);
    ptr_load = 1; ptr_value = 32'h100; @(negedge clk); ptr_load = 0;
    chk(cur_ptr == 32'h100, "R10", "pointer load", cur_ptr, 32'h100);

    // T1: one short frame, one buffer
    refill();
    expect_wb(32'h100, 16'h1C08, 16'd24);
    f0 = n_frame; i0 = n_irq;
    send_frame(20, 1);
    @(negedge clk);
    chk(in_ready == 0, "R1", "in_ready during walk", in_ready, 0);
    wait_idle();
    check_data(20, 1, 0, 64, '{32'h400}, "R5");
    chk(n_frame - f0 == 1 && n_irq - i0 == 1, "R9", "frame event and irq",
        {n_frame - f0, n_irq - i0}, {32'd1, 32'd1});
    chk(cur_ptr == 32'h108, "R10", "pointer after one", cur_ptr, 32'h108);

    // T2: control block, three buffers, wrap
    refill();
    parse_depth = 1; align_pad = 2; max_buf_len = 48;
    expect_wb(32'h108, 16'h1400, 16'd48);
    expect_wb(32'h110, 16'h1000, 16'd48);
    expect_wb(32'h118, 16'h3800, 16'd18);
    f0 = n_frame; b0 = n_buf; i0 = n_irq;
    send_frame(100, 7);
    wait_idle();
    check_data(100, 7, 10, 48, '{32'h500, 32'h600, 32'h700}, "R4");
    chk(n_buf - b0 == 2 && n_frame - f0 == 1, "R9", "buffer/frame events",
        {n_buf - b0, n_frame - f0}, {32'd2, 32'd1});
    chk(n_irq - i0 == 1, "R9", "irq masked for buffer events", n_irq - i0, 1);
    chk(cur_ptr == 32'h100, "R10", "wrap to ring base", cur_ptr, 32'h100);
    parse_depth = 0; align_pad = 0;

    // T3: length violation at the boundary
    refill();
    max_frame = 16'd100; max_buf_len = 128;
    expect_wb(32'h100, 16'h1C20, 16'd100);
    send_frame(96, 3);
    wait_idle();
    check_data(96, 3, 0, 128, '{32'h400}, "R8");
    max_frame = 16'd1518;

    // T4: byte-reversed descriptors, buffer irq enabled
    desc_le = 1; refill(); max_buf_len = 64; mask_buf = 1;
    expect_wb(32'h108, 16'h1C08, 16'd34);
    send_frame(30, 9);
    wait_idle();
    check_data(30, 9, 0, 64, '{32'h500}, "R12");
    chk(cur_ptr == 32'h110, "R12", "pointer after LE frame", cur_ptr, 32'h110);
    desc_le = 0; refill();

    // T5: discard while disabled or stopping
    rx_en = 0; r0 = n_req;
    send_frame(30, 2); wait_idle();
    chk(n_req == r0 && cur_ptr == 32'h110, "R2", "rx disabled untouched", n_req - r0, 0);
    rx_en = 1; grace_stop = 1; r0 = n_req;
    send_frame(30, 2); wait_idle();
    chk(n_req == r0 && cur_ptr == 32'h110, "R2", "graceful stop untouched", n_req - r0, 0);
    grace_stop = 0;

    // T6: short reject boundary
    short_reject = 1; r0 = n_req;
    send_frame(59, 4); wait_idle();
    chk(n_req == r0 && cur_ptr == 32'h110, "R3", "59-byte frame discarded", n_req - r0, 0);
    expect_wb(32'h110, 16'h1C00, 16'd64);
    send_frame(60, 4); wait_idle();
    chk(cur_ptr == 32'h118, "R3", "60-byte frame placed", cur_ptr, 32'h118);
    short_reject = 0;

    // T7: halt on a non-empty descriptor, then resume
    set_desc(3, 16'hB000); set_desc(0, 16'h9000); set_desc(1, 16'h1000);
    max_buf_len = 32;
    expect_wb(32'h118, 16'h3400, 16'd32);
    expect_wb(32'h100, 16'h1000, 16'd32);
    send_frame(80, 11);
    wait_idle();
    chk(halted == 1 && in_ready == 0, "R11", "halted and blocking",
        {halted, in_ready}, 2'b10);
    chk(cur_ptr == 32'h108, "R11", "pointer on busy descriptor", cur_ptr, 32'h108);
    chk(exp_q.size() == 0, "R11", "write-backs before halt", exp_q.size(), 0);
    set_desc(1, 16'h9000);
    expect_wb(32'h108, 16'h1800, 16'd20);
    @(negedge clk); halt_resume = 1; @(negedge clk); halt_resume = 0;
    wait_idle();
    chk(halted == 0 && cur_ptr == 32'h110, "R7", "resumed frame ends without first",
        cur_ptr, 32'h110);
    check_data(80, 11, 0, 32, '{32'h700, 32'h400, 32'h500}, "R6");

    // T8: halt after a full lap, resume with refilled ring
    refill(); max_buf_len = 8;
    expect_wb(32'h110, 16'h1400, 16'd8);
    expect_wb(32'h118, 16'h3000, 16'd8);
    expect_wb(32'h100, 16'h1000, 16'd8);
    expect_wb(32'h108, 16'h1000, 16'd8);
    send_frame(60, 20);
    wait_idle();
    chk(halted == 1 && cur_ptr == 32'h110, "R11", "halt after full lap", cur_ptr, 32'h110);
    refill();
    expect_wb(32'h110, 16'h1000, 16'd8);
    expect_wb(32'h118, 16'h3000, 16'd8);
    expect_wb(32'h100, 16'h1000, 16'd8);
    expect_wb(32'h108, 16'h1800, 16'd8);
    @(negedge clk); halt_resume = 1; @(negedge clk); halt_resume = 0;
    wait_idle();
    chk(halted == 0 && in_ready == 1, "R11", "frame finished after lap resume",
        {halted, in_ready}, 2'b01);
    chk(exp_q.size() == 0, "R6", "all write-backs seen", exp_q.size(), 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule